// File: doc/BRIEF.md
# Window-Integral Alarm Comparator

This block watches one stream of measured samples, such as a rail voltage, a load current or a temperature, and compares each sample against a programmable window. A low limit catches undervoltage and a high limit catches overvoltage or overcurrent. A per-direction duration integrator decides when to trip, so a single crossing does not raise an alarm. Only an excursion that persists raises one. Once an alarm is raised, the sample has to come back inside the window by a hysteresis margin before the alarm is released. A release then opens an inhibit window, and no new alarm can be raised while that window is open. A separate slope detector flags a jump between consecutive samples that is larger than a programmed rate.

Three status bits record the conditions and drive the active-low alert output. Bit 0 is the under condition, bit 1 the over condition and bit 2 the slope condition. In latched mode the bits are sticky and a host read strobe clears them. In auto-recover mode the bits follow the live alarm state. The usual use is one instance per monitored channel. The alert output goes to an interrupt line, and the read strobe is tied to the host's read of the status word.

Top module: `wia_top`

## Requirements
- R1: After reset, status_o is 3'b000 and alert_no is 1.
- R2: A valid sample is outside low when smp_i < lo_thr_i and outside high when smp_i > hi_thr_i (strict compares). The under alarm is status bit 0 and the over alarm is status bit 1.
- R3: Each direction has a duration count. On each valid sample the count goes up by one, saturating at the limit, while the sample is outside that side of the window. It goes down by one, saturating at zero, while the sample is not outside that side. An alarm trips on the sample where the count equals the limit. The limit is integ_i, and an integ_i of 0 behaves as 1.
- R4: An excursion of fewer consecutive samples than the limit, followed by samples inside the window, raises no alarm.
- R5: An active under alarm releases on a valid sample with smp_i >= lo_thr_i + hyst_i. An active over alarm releases on a valid sample with smp_i + hyst_i <= hi_thr_i. Both sums are computed without overflow. Until then the alarm stays active.
- R6: After a valid sample that releases an alarm, the next inhibit_i valid samples cannot raise any new under or over alarm. The duration counts keep running during that time.
- R7: With latch_mode_i=1, a set status bit holds until a cycle with rd_clr_i=1 clears all bits. On a valid sample, every alarm still active and any slope event set their bit again, even in the same cycle as the clear.
- R8: With latch_mode_i=0, status bits 0 and 1 equal the live alarm states, bit 2 equals the slope result of the latest valid sample, and rd_clr_i has no effect.
- R9: The slope flag is raised for a valid sample whose absolute difference from the previous valid sample exceeds slope_thr_i. The first valid sample after reset never raises it.
- R10: alert_no is 0 exactly when some status bit is 1 and its en_mask_i bit is also 1. It follows status_o in the same cycle.
- R11: A cycle with smp_valid_i=0 leaves the counts, the alarms, the inhibit window and the previous sample unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_valid_i | input | 1 | A new sample is present on smp_i |
| smp_i | input | DW | Measured sample, unsigned |
| lo_thr_i | input | DW | Low window limit |
| hi_thr_i | input | DW | High window limit |
| hyst_i | input | DW | Release margin inside the window |
| integ_i | input | CW | Samples an excursion must persist to trip |
| inhibit_i | input | IW | Samples blocked after a release |
| slope_thr_i | input | DW | Largest allowed sample-to-sample change |
| latch_mode_i | input | 1 | 1: sticky status, 0: auto-recover |
| en_mask_i | input | 3 | Per-bit enable of the alert output |
| rd_clr_i | input | 1 | Host read strobe, clears latched status |
| status_o | output | 3 | Status bits {slope, over, under} |
| alert_no | output | 1 | Alert, active low |

## Verification
The bench aims at the off-by-one edges of the integrator. A spike one sample shorter than the limit must not trip, and a design that trips on a crossing or resets the count on the first inside sample fails here. The release point is checked exactly at lo+hyst. The inhibit window is measured sample by sample, where an off-by-one length lets a new alarm in early or holds it out too long. A read-clear while the excursion persists is also checked: a lossy design would drop the bit, and a stuck design would keep alert_no low after a clear that should take effect. A sweep over limits, inhibit lengths and both modes compares every cycle with an arithmetic model.

// File: rtl/wia_pkg.sv
package wia_pkg;
  localparam int unsigned NSTAT   = 3;
  localparam int unsigned B_UNDER = 0;
  localparam int unsigned B_OVER  = 1;
  localparam int unsigned B_SLOPE = 2;
  localparam int unsigned NDIR    = 2;
  typedef logic [NSTAT-1:0] stat_t;
endpackage

// File: rtl/wia_integ.sv
module wia_integ #(
  parameter int unsigned CW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          outside_i,
  input  logic [CW-1:0] lim_i,
  output logic          hit_o
);
  logic [CW-1:0] cnt_q, cnt_n, lim_eff;

  assign lim_eff = (lim_i == '0) ? CW'(1) : lim_i;

  always_comb begin
    cnt_n = cnt_q;
    if (valid_i) begin
      if (outside_i) cnt_n = (cnt_q >= lim_eff) ? lim_eff : cnt_q + CW'(1);
      else           cnt_n = (cnt_q == '0) ? '0 : cnt_q - CW'(1);
    end
  end

  assign hit_o = valid_i && outside_i && (cnt_n == lim_eff);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_n;
  end

  AST_TRIP_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> ({1'b0, cnt_q} + (CW+1)'(1) >= {1'b0, lim_eff})); // R3
endmodule

// File: rtl/wia_slope.sv
module wia_slope #(
  parameter int unsigned DW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [DW-1:0] smp_i,
  input  logic [DW-1:0] thr_i,
  output logic          evt_o
);
  logic [DW-1:0] prev_q, diff;
  logic          have_q;

  assign diff  = (smp_i >= prev_q) ? smp_i - prev_q : prev_q - smp_i;
  assign evt_o = valid_i && have_q && (diff > thr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      have_q <= 1'b0;
    end else if (valid_i) begin
      prev_q <= smp_i;
      have_q <= 1'b1;
    end
  end

  AST_PREV_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(prev_q)); // R11
endmodule

// File: rtl/wia_top.sv
module wia_top
  import wia_pkg::*;
#(
  parameter int unsigned DW = 12,
  parameter int unsigned CW = 6,
  parameter int unsigned IW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          smp_valid_i,
  input  logic [DW-1:0] smp_i,
  input  logic [DW-1:0] lo_thr_i,
  input  logic [DW-1:0] hi_thr_i,
  input  logic [DW-1:0] hyst_i,
  input  logic [CW-1:0] integ_i,
  input  logic [IW-1:0] inhibit_i,
  input  logic [DW-1:0] slope_thr_i,
  input  logic          latch_mode_i,
  input  logic [2:0]    en_mask_i,
  input  logic          rd_clr_i,
  output logic [2:0]    status_o,
  output logic          alert_no
);
  localparam int unsigned XW = DW + 1;

  logic [NDIR-1:0] outside, hit, rel, act_q, act_n;
  logic [IW-1:0]   inh_q, inh_n;
  logic            slp_evt, slp_q, slp_n, release_any;
  stat_t           status_q, status_n, cur;

  assign outside[B_UNDER] = smp_i < lo_thr_i;
  assign outside[B_OVER]  = smp_i > hi_thr_i;
  assign rel[B_UNDER] = XW'(smp_i) >= XW'(lo_thr_i) + XW'(hyst_i);
  assign rel[B_OVER]  = XW'(smp_i) + XW'(hyst_i) <= XW'(hi_thr_i);

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    wia_integ #(.CW(CW)) integ_i0 (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .valid_i   (smp_valid_i),
      .outside_i (outside[d]),
      .lim_i     (integ_i),
      .hit_o     (hit[d])
    );
  end

  wia_slope #(.DW(DW)) slope_i0 (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (smp_valid_i),
    .smp_i   (smp_i),
    .thr_i   (slope_thr_i),
    .evt_o   (slp_evt)
  );

  always_comb begin
    act_n = act_q;
    inh_n = inh_q;
    if (smp_valid_i) begin
      for (int d = 0; d < int'(NDIR); d++) begin
        if (act_q[d]) begin
          if (rel[d]) act_n[d] = 1'b0;
        end else if (hit[d] && (inh_q == '0)) begin
          act_n[d] = 1'b1;
        end
      end
      if (release_any)       inh_n = inhibit_i;
      else if (inh_q != '0)  inh_n = inh_q - IW'(1);
    end
  end

  assign release_any = |(act_q & ~act_n);
  assign slp_n = smp_valid_i ? slp_evt : slp_q;
  assign cur   = {slp_n, act_n};

  always_comb begin
    if (latch_mode_i)
      status_n = (status_q & ~{NSTAT{rd_clr_i}}) | (smp_valid_i ? cur : '0);
    else
      status_n = cur;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q    <= '0;
      inh_q    <= '0;
      slp_q    <= 1'b0;
      status_q <= '0;
    end else begin
      act_q    <= act_n;
      inh_q    <= inh_n;
      slp_q    <= slp_n;
      status_q <= status_n;
    end
  end

  assign status_o = status_q;
  assign alert_no = ~|(status_q & en_mask_i);

  AST_INH_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_i && inh_q != '0) |=> ((act_q & ~$past(act_q)) == '0)); // R6
  AST_LATCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latch_mode_i && !rd_clr_i) |=> ((status_q & $past(status_q)) == $past(status_q))); // R7
  AST_AUTO_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!latch_mode_i && smp_valid_i) |=> (status_q[1:0] == act_q)); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!smp_valid_i && !rd_clr_i && latch_mode_i == $past(latch_mode_i)) |=> $stable(status_q)); // R11
endmodule

// File: tb/wia_top_tb_top.sv
module wia_top_tb_top;
  localparam int DW = 8;
  localparam int CW = 4;
  localparam int IW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          valid = 1'b0;
  logic [DW-1:0] smp = '0, lo = 8'd50, hi = 8'd200, hyst = 8'd10, sthr = 8'd255;
  logic [CW-1:0] integ = 4'd3;
  logic [IW-1:0] inhib = 4'd2;
  logic          latch = 1'b0;
  logic [2:0]    mask = 3'b111;
  logic          clr = 1'b0;
  logic [2:0]    status;
  logic          alert_n;

  int total = 0, bad = 0;
  bit done = 0;

  // reference state
  int m_cnt[2], m_act[2], m_inh, m_prev, m_havep, m_slp, m_stat;

  always #2 clk = ~clk;

  wia_top #(.DW(DW), .CW(CW), .IW(IW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .smp_valid_i(valid), .smp_i(smp),
    .lo_thr_i(lo), .hi_thr_i(hi), .hyst_i(hyst), .integ_i(integ),
    .inhibit_i(inhib), .slope_thr_i(sthr), .latch_mode_i(latch),
    .en_mask_i(mask), .rd_clr_i(clr), .status_o(status), .alert_no(alert_n)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model(input int v, input int s, input int c);
    int cur, lim, rel[2], outs[2], hit[2], rl;
    if (v != 0) begin
      lim = (integ == 0) ? 1 : int'(integ);
      outs[0] = (s < int'(lo)) ? 1 : 0;
      outs[1] = (s > int'(hi)) ? 1 : 0;
      rel[0] = (s >= int'(lo) + int'(hyst)) ? 1 : 0;
      rel[1] = (s + int'(hyst) <= int'(hi)) ? 1 : 0;
      rl = 0;
      for (int k = 0; k < 2; k++) begin
        if (outs[k] != 0) m_cnt[k] = (m_cnt[k] >= lim) ? lim : m_cnt[k] + 1;
        else if (m_cnt[k] > 0) m_cnt[k]--;
        hit[k] = (outs[k] != 0 && m_cnt[k] == lim) ? 1 : 0;
      end
      for (int k = 0; k < 2; k++) begin
        if (m_act[k] != 0) begin
          if (rel[k] != 0) begin m_act[k] = 0; rl = 1; end
        end else if (hit[k] != 0 && m_inh == 0) m_act[k] = 1;
      end
      if (rl != 0) m_inh = int'(inhib);
      else if (m_inh > 0) m_inh--;
      m_slp = (m_havep != 0 && ((s > m_prev) ? s - m_prev : m_prev - s) > int'(sthr)) ? 1 : 0;
      m_prev = s;
      m_havep = 1;
    end
    cur = m_slp * 4 + m_act[1] * 2 + m_act[0];
    if (latch) m_stat = ((c != 0) ? 0 : m_stat) | ((v != 0) ? cur : 0);
    else       m_stat = cur;
  endtask

  task automatic step(input string tag, input int v, input int s, input int c);
    valid = v[0];
    smp   = DW'(s);
    clr   = c[0];
    model(v, s, c);
    @(posedge clk);
    @(negedge clk);
    chk({tag, " status"}, int'(status), m_stat);
    chk({"R10 alert via ", tag}, int'(alert_n), ((m_stat & int'(mask)) != 0) ? 0 : 1);
    valid = 1'b0;
    clr   = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    valid = 1'b0;
    clr   = 1'b0;
    m_cnt[0] = 0; m_cnt[1] = 0; m_act[0] = 0; m_act[1] = 0;
    m_inh = 0; m_prev = 0; m_havep = 0; m_slp = 0; m_stat = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    chk("R1 status", int'(status), 0);
    chk("R1 alert", int'(alert_n), 1);

    // first sample never flags slope
    sthr = 8'd0;
    step("R9 first", 1, 100, 0);
    chk("R9 first no slope", int'(status[2]), 0);
    step("R9 jump", 1, 101, 0);
    chk("R9 diff1 thr0", int'(status[2]), 1);
    sthr = 8'd255;
    step("R8 slope follows", 1, 100, 0);
    chk("R8 slope bit follows", int'(status[2]), 0);

    // short spikes below limit 3
    step("R4", 1, 40, 0);
    step("R4", 1, 40, 0);
    step("R4", 1, 60, 0);
    step("R4", 1, 40, 0);
    chk("R4 no trip", int'(status), 0);
    step("R4", 1, 100, 0);
    step("R4", 1, 100, 0);
    // persistent excursion
    step("R3", 1, 40, 0);
    step("R3", 1, 40, 0);
    chk("R3 not yet", int'(status[0]), 0);
    step("R3", 1, 49, 0);
    chk("R3 trip on third", int'(status[0]), 1);
    chk("R10 alert low", int'(alert_n), 0);
    step("R11 idle", 0, 0, 0);
    chk("R11 idle holds", int'(status[0]), 1);
    step("R8 clr ignored", 0, 0, 1);
    chk("R8 clr ignored", int'(status[0]), 1);
    // hysteresis: release at lo+hyst = 60
    step("R5", 1, 55, 0);
    step("R5", 1, 59, 0);
    chk("R5 held at 59", int'(status[0]), 1);
    step("R5", 1, 60, 0);
    chk("R5 release at 60", int'(status[0]), 0);
    // inhibit of two samples
    step("R6", 1, 40, 0);
    step("R6", 1, 40, 0);
    chk("R6 blocked", int'(status[0]), 0);
    step("R6", 1, 40, 0);
    chk("R6 trips after window", int'(status[0]), 1);
    step("R5", 1, 60, 0);
    // over side
    step("R2", 1, 201, 0);
    step("R2", 1, 201, 0);
    step("R2", 1, 201, 0);
    step("R2", 1, 201, 0);
    chk("R2 over bit", int'(status), 2);
    step("R2", 1, 190, 0);
    chk("R2 over release", int'(status[1]), 0);
    step("R2", 1, 200, 0);
    chk("R2 edge inside", int'(status), 0);
    mask = 3'b000;
    step("R10", 1, 200, 0);

    // latched mode
    mask = 3'b111;
    latch = 1'b1;
    inhib = 4'd0;
    integ = 4'd0;
    step("R7", 1, 10, 0);
    chk("R7 limit0 trips at once", int'(status[0]), 1);
    step("R7 clr", 0, 0, 1);
    chk("R7 cleared", int'(status[0]), 0);
    chk("R7 alert rearmed", int'(alert_n), 1);
    step("R7", 1, 10, 0);
    chk("R7 re-set still present", int'(status[0]), 1);
    step("R7", 1, 100, 0);
    chk("R7 hold after release", int'(status[0]), 1);
    step("R7 clr", 1, 100, 1);
    chk("R7 clear effective", int'(status), 0);

    // sweep
    for (int lm = 0; lm < 2; lm++)
      for (int ig = 0; ig < 4; ig++)
        for (int ih = 0; ih < 3; ih++) begin
          latch = lm[0];
          integ = CW'(ig);
          inhib = IW'(ih);
          sthr  = 8'd60;
          do_reset();
          for (int n = 0; n < 80; n++) begin
            int r, s;
            r = int'($urandom_range(0, 9));
            case (r)
              0, 1, 2: s = int'($urandom_range(35, 65));
              3, 4, 5: s = int'($urandom_range(185, 215));
              default: s = int'($urandom_range(0, 255));
            endcase
            mask = 3'($urandom_range(0, 7));
            step("R2 R3 R5 R6 sweep", ($urandom_range(0, 9) < 8) ? 1 : 0, s,
                 ($urandom_range(0, 9) == 0) ? 1 : 0);
          end
        end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule